// File: doc/BRIEF.md
# Timer Output Compare Unit

This block holds a 16-bit compare value that the processor loads one byte at a time, and it watches a free-running 16-bit counter for that value. The counter is built into the block. It advances once every four bus clocks. When the counter steps onto the compare value, the block does three things on the same clock edge:

- it sets a compare flag;
- it copies a programmed level bit into the register that drives the output pin;
- it raises an interrupt if interrupts are enabled.

Software gets a new timeout by loading the next compare value and, if it wants, a new level.

Loading the high byte disarms the comparator, and loading the low byte arms it again. The comparator therefore never acts on a value that is only half updated. The compare bytes hold no defined value after reset. The comparator stays disarmed from reset until the first low-byte write. To clear the flag, software first reads status while the flag is set and then writes the low compare byte.

Top module: `toc_unit`

## Requirements
- R1: After reset release the counter starts at 0 and increases by exactly one every 4 bus clocks. It wraps modulo 2^16 and is visible on `cnt_value`.
- R2: While reset is asserted, `cnt_value`, `cmp_flag`, `cmp_irq` and `pin_level` are all 0.
- R3: When the comparator is armed, `cmp_flag` becomes 1 on the clock edge at which the counter takes a value equal to the compare value {high byte, low byte}. The high byte is the write with `wr_hi`=1 and the low byte is the write with `wr_hi`=0.
- R4: On a match edge `pin_level` takes the value of `cfg_level`. On every other edge it keeps its value, whatever `cfg_level` does.
- R5: `cmp_irq` is 1 exactly when `cmp_flag` is 1 and `cfg_irq_en` is 1. It follows `cfg_irq_en` without a clock delay.
- R6: A high-byte write disarms the comparator, so no match occurs, even for the partially updated value. The next low-byte write re-arms it. The comparator is also disarmed from reset until the first low-byte write.
- R7: `cmp_flag` is cleared by a low-byte write only if `stat_rd` was pulsed while the flag was already set. A low-byte write without that read leaves the flag at 1. A match in the same cycle as a clearing write keeps the flag at 1.
- R8: A match is detected only on the edge where the counter changes value. Clearing the flag while the counter still equals the compare value does not set it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Compare byte write strobe, one cycle per byte |
| wr_hi | input | 1 | Byte select: 1 high byte, 0 low byte |
| wr_data | input | 8 | Byte written |
| stat_rd | input | 1 | Status read strobe, first step of the flag clear |
| cfg_level | input | 1 | Level copied to the pin on a match |
| cfg_irq_en | input | 1 | Interrupt enable for the compare flag |
| cnt_value | output | 16 | Free-running counter value |
| cmp_flag | output | 1 | Compare flag |
| cmp_irq | output | 1 | Interrupt request |
| pin_level | output | 1 | Output level register driving the pin |

## Verification
The bench loads only the high byte, so that the half-updated value is one the counter reaches soon afterwards. A design without the write interlock would then produce an unexpected flag, and the scoreboard reports it. The bench also clears the flag while the counter still sits on the compare value. A comparator that checks on every bus cycle instead of once per counter step would set the flag again at once.

Further cases cover the clear sequence:
- a low-byte write without a prior status read must leave the flag set, so a single-step clear would show up;
- the pin must hold while `cfg_level` toggles between matches, so a pin that follows the level bit directly would show up;
- the match count and the pin level are compared at each flag rise, so an off-by-one match point would show up.

// File: rtl/toc_pkg.sv
package toc_pkg;
  typedef enum logic {
    SEL_LO = 1'b0,
    SEL_HI = 1'b1
  } byte_sel_e;

  function automatic int unsigned div_width(input int unsigned div);
    return (div > 1) ? $clog2(div) : 1;
  endfunction
endpackage

// File: rtl/toc_rst_sync.sv
module toc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic s0_q, s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_q <= 1'b0;
      s1_q <= 1'b0;
    end else begin
      s0_q <= 1'b1;
      s1_q <= s0_q;
    end
  end

  assign rst_sync_n = s1_q;
endmodule

// File: rtl/toc_prescale.sv
module toc_prescale #(
  parameter int unsigned DIV   = 4,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_ni,
  output logic             tick_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_next_o
);
  localparam int unsigned PRE_W = toc_pkg::div_width(DIV);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(DIV - 1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tick;

  always_comb begin
    tick  = (pre_q == PRE_LAST);
    pre_d = tick ? '0 : pre_q + PRE_W'(1);
    cnt_d = tick ? cnt_q + CNT_W'(1) : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= pre_d;
      cnt_q <= cnt_d;
    end
  end

  assign tick_o     = tick;
  assign cnt_o      = cnt_q;
  assign cnt_next_o = cnt_q + CNT_W'(1);

  // R1: the counter moves only after a prescaler wrap
  p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    !$stable(cnt_q) |-> $past(tick));
endmodule

// File: rtl/toc_cmpreg.sv
module toc_cmpreg #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned CNT_W  = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_hi_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [CNT_W-1:0]  cmp_o,
  output logic              armed_o,
  output logic              lo_wr_o
);
  import toc_pkg::*;

  byte_sel_e         sel;
  logic              hi_we, lo_we;
  logic              armed_q, armed_d;
  logic [BYTE_W-1:0] hi_q, lo_q;

  always_comb begin
    sel     = byte_sel_e'(wr_hi_i);
    hi_we   = wr_en_i && (sel == SEL_HI);
    lo_we   = wr_en_i && (sel == SEL_LO);
    armed_d = armed_q;
    if (hi_we) armed_d = 1'b0;
    if (lo_we) armed_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (hi_we) hi_q <= wr_data_i;
  end

  always_ff @(posedge clk) begin
    if (lo_we) lo_q <= wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= armed_d;
  end

  assign cmp_o   = {hi_q, lo_q};
  assign armed_o = armed_q;
  assign lo_wr_o = lo_we;

  // R6: high byte write leaves the comparator disarmed
  p_hi_disarms_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en_i && wr_hi_i) |=> !armed_o);
  p_lo_arms_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en_i && !wr_hi_i) |=> armed_o);
endmodule

// File: rtl/toc_flag.sv
module toc_flag (
  input  logic clk,
  input  logic rst_ni,
  input  logic match_i,
  input  logic level_i,
  input  logic stat_rd_i,
  input  logic lo_wr_i,
  output logic flag_o,
  output logic pin_o
);
  logic flag_q, flag_d;
  logic seen_q, seen_d;
  logic pin_q, pin_d;
  logic clr;

  always_comb begin
    clr    = lo_wr_i && seen_q;
    flag_d = match_i ? 1'b1 : (clr ? 1'b0 : flag_q);
    if (match_i || clr) seen_d = 1'b0;
    else                seen_d = seen_q || (stat_rd_i && flag_q);
    pin_d  = match_i ? level_i : pin_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      seen_q <= 1'b0;
      pin_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      seen_q <= seen_d;
      pin_q  <= pin_d;
    end
  end

  assign flag_o = flag_q;
  assign pin_o  = pin_q;

  // R3: flag rises only after a detected match
  p_flag_rise_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(match_i));
  // R7: flag falls only through a low byte write
  p_flag_fall_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(flag_q) |-> $past(lo_wr_i));
  // R4: pin holds without a match
  p_pin_hold_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    !match_i |=> $stable(pin_q));
endmodule

// File: rtl/toc_unit.sv
module toc_unit #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned DIV    = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  wr_hi,
  input  logic [BYTE_W-1:0]     wr_data,
  input  logic                  stat_rd,
  input  logic                  cfg_level,
  input  logic                  cfg_irq_en,
  output logic [2*BYTE_W-1:0]   cnt_value,
  output logic                  cmp_flag,
  output logic                  cmp_irq,
  output logic                  pin_level
);
  localparam int unsigned CNT_W = 2 * BYTE_W;

  logic             rst_ni;
  logic             tick;
  logic [CNT_W-1:0] cnt, cnt_next, cmp;
  logic             armed, lo_wr, match;

  toc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_ni)
  );

  toc_prescale #(.DIV(DIV), .CNT_W(CNT_W)) u_pre (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .tick_o     (tick),
    .cnt_o      (cnt),
    .cnt_next_o (cnt_next)
  );

  toc_cmpreg #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_reg (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_hi_i   (wr_hi),
    .wr_data_i (wr_data),
    .cmp_o     (cmp),
    .armed_o   (armed),
    .lo_wr_o   (lo_wr)
  );

  always_comb begin
    match = tick && armed && (cnt_next == cmp);
  end

  toc_flag u_flag (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .match_i   (match),
    .level_i   (cfg_level),
    .stat_rd_i (stat_rd),
    .lo_wr_i   (lo_wr),
    .flag_o    (cmp_flag),
    .pin_o     (pin_level)
  );

  assign cmp_irq   = cmp_flag && cfg_irq_en;
  assign cnt_value = cnt;

  // R8: a match can only happen on a counter step
  p_match_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    match |-> tick);
  // R5: no request without the flag
  p_irq_needs_flag_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    !cmp_flag |-> !cmp_irq);
endmodule

// File: tb/test_toc_unit.sv
`timescale 1ns/1ps
module test_toc_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, wr_hi, stat_rd, cfg_level, cfg_irq_en;
  logic [7:0]  wr_data;
  logic [15:0] cnt_value;
  logic        cmp_flag, cmp_irq, pin_level;

  typedef struct { logic [15:0] cnt; logic lvl; } exp_t;
  exp_t exp_q[$];

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit mon_on = 1'b0;

  always #2.5 clk = ~clk;

  toc_unit i_toc_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_hi(wr_hi), .wr_data(wr_data),
    .stat_rd(stat_rd), .cfg_level(cfg_level), .cfg_irq_en(cfg_irq_en),
    .cnt_value(cnt_value), .cmp_flag(cmp_flag), .cmp_irq(cmp_irq),
    .pin_level(pin_level)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_byte(input logic hi, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_hi = hi; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_stat();
    @(negedge clk);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  task automatic arm(input logic [15:0] v, input logic lvl);
    exp_t e;
    e.cnt = v; e.lvl = lvl;
    cfg_level = lvl;
    exp_q.push_back(e);
    write_byte(1'b1, v[15:8]);
    write_byte(1'b0, v[7:0]);
  endtask

  task automatic wait_flag();
    while (!cmp_flag) @(negedge clk);
  endtask

  task automatic wait_cnt(input logic [15:0] v);
    while (cnt_value < v) @(negedge clk);
  endtask

  // monitor: pop expected match on each flag rise
  initial begin
    logic prev;
    prev = 1'b0;
    forever begin
      @(negedge clk);
      if (mon_on && cmp_flag && !prev) begin
        if (exp_q.size() == 0) begin
          check("R3/R6 unexpected match", {16'h0, cnt_value}, 32'hFFFFFFFF);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check("R3 match count", {16'h0, cnt_value}, {16'h0, e.cnt});
          check("R4 pin level", {31'h0, pin_level}, {31'h0, e.lvl});
        end
      end
      prev = cmp_flag;
    end
  end

  initial begin
    #(5.0 * 50000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] c0;
    rst_n = 1'b0; wr_en = 1'b0; wr_hi = 1'b0; wr_data = '0;
    stat_rd = 1'b0; cfg_level = 1'b0; cfg_irq_en = 1'b0;
    repeat (4) @(negedge clk);
    check("R2 cnt", {16'h0, cnt_value}, 32'h0);
    check("R2 flag", {31'h0, cmp_flag}, 32'h0);
    check("R2 irq", {31'h0, cmp_irq}, 32'h0);
    check("R2 pin", {31'h0, pin_level}, 32'h0);
    rst_n = 1'b1;
    mon_on = 1'b1;
    repeat (6) @(negedge clk);

    // R1: 40 clocks -> 10 counts
    c0 = cnt_value;
    repeat (40) @(negedge clk);
    check("R1 rate", {16'h0, cnt_value}, {16'h0, c0 + 16'd10});

    // R3/R4/R5 first match, level 1
    cfg_irq_en = 1'b0;
    arm(16'h0040, 1'b1);
    wait_flag();
    check("R5 irq masked", {31'h0, cmp_irq}, 32'h0);
    cfg_irq_en = 1'b1;
    #1;
    check("R5 irq enabled", {31'h0, cmp_irq}, 32'h1);

    // R7: low write without status read keeps flag
    write_byte(1'b0, 8'h10);
    repeat (3) @(negedge clk);
    check("R7 no read keeps flag", {31'h0, cmp_flag}, 32'h1);
    read_stat();
    write_byte(1'b0, 8'h10);
    check("R7 clear", {31'h0, cmp_flag}, 32'h0);
    check("R5 irq after clear", {31'h0, cmp_irq}, 32'h0);

    // R4: pin holds while level toggles
    cfg_level = 1'b0;
    repeat (8) @(negedge clk);
    cfg_level = 1'b1;
    repeat (3) @(negedge clk);
    check("R4 pin hold", {31'h0, pin_level}, 32'h1);

    // R8: clear while counter still equals compare
    arm(16'h0080, 1'b0);
    wait_flag();
    read_stat();
    write_byte(1'b0, 8'h80);
    @(negedge clk);
    check("R8 no reset same tick", {31'h0, cmp_flag}, 32'h0);
    repeat (4) @(negedge clk);
    check("R8 still clear", {31'h0, cmp_flag}, 32'h0);

    // R6: partial update must not match
    arm(16'h0120, 1'b1);
    wait_flag();
    read_stat();
    write_byte(1'b0, 8'h20);
    write_byte(1'b1, 8'h02);
    wait_cnt(16'h0230);
    check("R6 partial no match", {31'h0, cmp_flag}, 32'h0);
    check("R4 pin kept", {31'h0, pin_level}, 32'h1);
    exp_q.push_back('{cnt: 16'h0240, lvl: 1'b0});
    cfg_level = 1'b0;
    write_byte(1'b0, 8'h40);
    wait_flag();
    repeat (2) @(negedge clk);
    check("R6 rearmed match", {31'h0, cmp_flag}, 32'h1);
    check("R3 queue drained", exp_q.size(), 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule